// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache Controller

This block sits between a CPU request port and a main-memory controller. It holds a small direct-mapped data cache of 8 lines. Each line has 32 byte-wide words, so the cache holds 256 bytes. For each line it keeps a tag, a valid bit and a dirty bit. The word storage is an internal array.

Writes stay in the cache and mark the line dirty. A write that misses first allocates the line. When a miss lands on a dirty line, the whole old block is written back to main memory before the new block is fetched. After a fill the controller looks up the request again and finishes it as a hit. Blocks move through a strobed burst: the controller raises a strobe once the word address and direction are set, and it advances one word for each acknowledge from memory.

The CPU side is simple. While `cpu_ready` is high, a cycle with `cpu_sel` high hands over the address, the direction and the write data. `cpu_ready` then stays low until the operation is complete. For a read, `cpu_rdata` holds the word from the moment `cpu_ready` returns high.

Top module: `dcache_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `cpu_ready` is 1 and `mem_strobe` is 0.
- R2: A request is taken only when `cpu_ready` and `cpu_sel` are both 1 at a clock edge. `cpu_ready` is 0 from the next cycle until the operation completes. With `cpu_sel` at 0, the controller stays ready and makes no memory traffic.
- R3: A read hit makes no memory traffic. `cpu_ready` is low for exactly one cycle, then `cpu_rdata` returns the cached word at address bits [4:0] of the line selected by bits [7:5]. The line's stored tag must equal bits [15:8].
- R4: A write hit makes no memory traffic and keeps `cpu_ready` low for exactly one cycle. A later read of that address returns the written byte.
- R5: A fill issues exactly 32 memory reads (`mem_wr`=0). Their word addresses are {request tag, index, offset}, with the offset rising from 0 to 31.
- R6: A miss on a dirty line first issues 32 memory writes (`mem_wr`=1) to {stored tag, index, 0..31}. These carry the line's current contents. The fill of the new block follows.
- R7: After a fill, the original request completes: a read returns the fetched word, and a write merges its byte into the fetched block.
- R8: A memory word moves only at a clock edge where `mem_strobe` and `mem_ack` are both 1. Until then, the strobe, address and direction stay unchanged.
- R9: Reset clears every valid bit. An access whose tag equals a line's leftover stored tag still misses and fills.
- R10: A miss on a clean line makes no memory writes; only the fill is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | 1 | CPU request select |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Byte address {tag, index, offset} |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid when ready returns |
| cpu_ready | output | 1 | Controller idle and able to accept |
| mem_addr | output | 16 | Main-memory word address |
| mem_wr | output | 1 | Burst direction, 1 = write to memory |
| mem_strobe | output | 1 | Word transfer request |
| mem_ack | input | 1 | Memory accepts or delivers the current word |
| mem_wdata | output | 8 | Write-back data to memory |
| mem_rdata | input | 8 | Fill data from memory |

## Verification
A wrong tag, valid or dirty bit does not show at once. It shows on the next access to that line. A bad hit returns stale data in `cpu_rdata` one cycle after acceptance. A wrong miss shows a burst of 32 transfers where none was due. A dirty bit that is lost drops the write-back, so main memory keeps old bytes; that shows only after the line is evicted. The bench therefore logs every acknowledged memory word with its address, direction and data. It compares each log and each read against a shadow byte model kept from the requirements.

// File: rtl/dcc_pkg.sv
// Package: shared geometry and state encoding for the cache controller.
// Assumes byte-wide words and a direct-mapped organisation.
package dcc_pkg;
    localparam int TAG_W  = 8;
    localparam int IDX_W  = 3;
    localparam int OFF_W  = 5;
    localparam int DATA_W = 8;
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_FLUSH = 2'd2,
        ST_FILL  = 2'd3
    } dcc_state_t;
endpackage

// File: rtl/dcc_tag_store.sv
// Tag store: one tag, valid bit and dirty bit per line, read asynchronously
// at the selected index. Assumes at most one update request per cycle.
module dcc_tag_store #(
    parameter int TAG_W = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             install,
    input  logic [TAG_W-1:0] new_tag,
    input  logic             mark_dirty,
    input  logic             clean,
    output logic [TAG_W-1:0] cur_tag,
    output logic             cur_valid,
    output logic             cur_dirty
);
    localparam int LINES = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;

    // Tag array: written when a fill completes, no reset needed.
    always_ff @(posedge clk) begin
        if (install) tag_q[idx] <= new_tag;
    end

    // Status bits: cleared by reset, set or cleared by the controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (install) begin
                valid_q[idx] <= 1'b1;
                dirty_q[idx] <= 1'b0;
            end
            if (mark_dirty) dirty_q[idx] <= 1'b1;
            if (clean)      dirty_q[idx] <= 1'b0;
        end
    end

    // Lookup at the current index.
    always_comb begin
        cur_tag   = tag_q[idx];
        cur_valid = valid_q[idx];
        cur_dirty = dirty_q[idx];
    end

    // R6: a completed write-back leaves the line clean.
    a_r6_clean_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clean |=> !cur_dirty);
    // R4: marking a line dirty is seen on the next cycle.
    a_r4_dirty_sets: assert property (@(posedge clk) disable iff (!rst_n)
        mark_dirty |=> cur_dirty);
endmodule

// File: rtl/dcc_data_ram.sv
// Cache word storage: one synchronous write port and an asynchronous read
// of the same address. Contents are undefined until filled.
module dcc_data_ram #(
    parameter int DATA_W = 8,
    parameter int AW     = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Word write.
    always_ff @(posedge clk) begin
        if (we) mem_q[addr] <= wdata;
    end

    // Word read.
    assign rdata = mem_q[addr];
endmodule

// File: rtl/dcc_ctrl.sv
// Controller: latches a CPU request, checks for a hit, and runs write-back
// and fill bursts one word per memory acknowledge. After a fill it
// re-evaluates the request and then completes it as a hit.
module dcc_ctrl
    import dcc_pkg::*;
#(
    parameter int TAG_W  = dcc_pkg::TAG_W,
    parameter int IDX_W  = dcc_pkg::IDX_W,
    parameter int OFF_W  = dcc_pkg::OFF_W,
    parameter int DATA_W = dcc_pkg::DATA_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cpu_sel,
    input  logic                     cpu_wr,
    input  logic [TAG_W+IDX_W+OFF_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0]        cpu_wdata,
    output logic [DATA_W-1:0]        cpu_rdata,
    output logic                     cpu_ready,
    output logic [TAG_W+IDX_W+OFF_W-1:0] mem_addr,
    output logic                     mem_wr,
    output logic                     mem_strobe,
    input  logic                     mem_ack,
    output logic [DATA_W-1:0]        mem_wdata,
    input  logic [DATA_W-1:0]        mem_rdata,
    output logic [IDX_W-1:0]         ts_idx,
    output logic                     ts_install,
    output logic [TAG_W-1:0]         ts_new_tag,
    output logic                     ts_mark_dirty,
    output logic                     ts_clean,
    input  logic [TAG_W-1:0]         ts_tag,
    input  logic                     ts_valid,
    input  logic                     ts_dirty,
    output logic                     ram_we,
    output logic [IDX_W+OFF_W-1:0]   ram_addr,
    output logic [DATA_W-1:0]        ram_wdata,
    input  logic [DATA_W-1:0]        ram_rdata
);
    localparam int ADDR_W = TAG_W + IDX_W + OFF_W;
    localparam logic [OFF_W-1:0] LAST_OFF = '1;

    dcc_state_t        st_q, st_d;
    logic [OFF_W-1:0]  cnt_q;
    logic [TAG_W-1:0]  req_tag_q;
    logic [IDX_W-1:0]  req_idx_q;
    logic [OFF_W-1:0]  req_off_q;
    logic              req_wr_q;
    logic [DATA_W-1:0] req_wd_q;
    logic              hit, burst, step, last;

    assign hit   = ts_valid && (ts_tag == req_tag_q);
    assign burst = (st_q == ST_FLUSH) || (st_q == ST_FILL);
    assign step  = burst && mem_ack;
    assign last  = (cnt_q == LAST_OFF);

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cpu_sel) st_d = ST_EVAL;
            ST_EVAL:  st_d = hit ? ST_IDLE : (ts_dirty ? ST_FLUSH : ST_FILL);
            ST_FLUSH: if (step && last) st_d = ST_FILL;
            ST_FILL:  if (step && last) st_d = ST_EVAL;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State and burst offset registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q <= st_d;
            if (step) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_tag_q <= '0;
            req_idx_q <= '0;
            req_off_q <= '0;
            req_wr_q  <= 1'b0;
            req_wd_q  <= '0;
        end else if (st_q == ST_IDLE && cpu_sel) begin
            req_tag_q <= cpu_addr[ADDR_W-1 -: TAG_W];
            req_idx_q <= cpu_addr[OFF_W +: IDX_W];
            req_off_q <= cpu_addr[OFF_W-1:0];
            req_wr_q  <= cpu_wr;
            req_wd_q  <= cpu_wdata;
        end
    end

    // Read data register, loaded on a read hit.
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_rdata <= '0;
        else if (st_q == ST_EVAL && hit && !req_wr_q) cpu_rdata <= ram_rdata;
    end

    // Datapath selects toward the SRAM, the tag store and main memory.
    always_comb begin
        cpu_ready     = (st_q == ST_IDLE);
        ts_idx        = req_idx_q;
        ts_new_tag    = req_tag_q;
        ts_install    = (st_q == ST_FILL) && step && last;
        ts_clean      = (st_q == ST_FLUSH) && step && last;
        ts_mark_dirty = (st_q == ST_EVAL) && hit && req_wr_q;
        ram_addr      = burst ? {req_idx_q, cnt_q} : {req_idx_q, req_off_q};
        ram_we        = ((st_q == ST_FILL) && step) || ts_mark_dirty;
        ram_wdata     = (st_q == ST_FILL) ? mem_rdata : req_wd_q;
        mem_strobe    = burst;
        mem_wr        = (st_q == ST_FLUSH);
        mem_addr      = {((st_q == ST_FLUSH) ? ts_tag : req_tag_q), req_idx_q, cnt_q};
        mem_wdata     = ram_rdata;
    end

    // R2: an accepted request drops ready on the next cycle.
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_sel) |=> !cpu_ready);
    // R3: a hit completes in the evaluation cycle.
    a_r3_hit_done: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EVAL && hit) |=> cpu_ready);
    // R8: without acknowledge the transfer holds still.
    a_r8_strobe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_strobe && !mem_ack) |=> (mem_strobe && $stable(mem_addr) && $stable(mem_wr)));
    // R5: within a burst the word offset rises by one per acknowledge.
    a_r5_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_strobe && mem_ack && (mem_addr[OFF_W-1:0] != LAST_OFF))
        |=> (mem_strobe && (mem_addr[OFF_W-1:0] == $past(mem_addr[OFF_W-1:0]) + 1'b1)));
    // R10: a miss on a clean line goes straight to the fill.
    a_r10_clean_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EVAL && !hit && !ts_dirty) |=> (st_q == ST_FILL && !mem_wr));
    // R6: a miss on a dirty line starts with a write-back.
    a_r6_dirty_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_EVAL && !hit && ts_dirty) |=> (mem_strobe && mem_wr));
endmodule

// File: rtl/dcache_ctrl.sv
// Top: direct-mapped write-back, write-allocate cache controller with an
// internal word array. Main memory is reached through a strobe/acknowledge
// burst port, one word per acknowledge.
module dcache_ctrl #(
    parameter int TAG_W  = dcc_pkg::TAG_W,
    parameter int IDX_W  = dcc_pkg::IDX_W,
    parameter int OFF_W  = dcc_pkg::OFF_W,
    parameter int DATA_W = dcc_pkg::DATA_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_sel,
    input  logic                         cpu_wr,
    input  logic [TAG_W+IDX_W+OFF_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0]            cpu_wdata,
    output logic [DATA_W-1:0]            cpu_rdata,
    output logic                         cpu_ready,
    output logic [TAG_W+IDX_W+OFF_W-1:0] mem_addr,
    output logic                         mem_wr,
    output logic                         mem_strobe,
    input  logic                         mem_ack,
    output logic [DATA_W-1:0]            mem_wdata,
    input  logic [DATA_W-1:0]            mem_rdata
);
    localparam int RAM_AW = IDX_W + OFF_W;

    logic [IDX_W-1:0]  ts_idx;
    logic              ts_install, ts_mark_dirty, ts_clean;
    logic [TAG_W-1:0]  ts_new_tag, ts_tag;
    logic              ts_valid, ts_dirty;
    logic              ram_we;
    logic [RAM_AW-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata, ram_rdata;

    dcc_ctrl #(.TAG_W(TAG_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
        .mem_addr(mem_addr), .mem_wr(mem_wr), .mem_strobe(mem_strobe),
        .mem_ack(mem_ack), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .ts_idx(ts_idx), .ts_install(ts_install), .ts_new_tag(ts_new_tag),
        .ts_mark_dirty(ts_mark_dirty), .ts_clean(ts_clean),
        .ts_tag(ts_tag), .ts_valid(ts_valid), .ts_dirty(ts_dirty),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    dcc_tag_store #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .idx(ts_idx), .install(ts_install),
        .new_tag(ts_new_tag), .mark_dirty(ts_mark_dirty), .clean(ts_clean),
        .cur_tag(ts_tag), .cur_valid(ts_valid), .cur_dirty(ts_dirty)
    );

    dcc_data_ram #(.DATA_W(DATA_W), .AW(RAM_AW)) u_ram (
        .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata),
        .rdata(ram_rdata)
    );

    // R1: the controller is ready and quiet in the cycle after reset.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (cpu_ready && !mem_strobe));
endmodule

// File: tb/sim_dcache_ctrl.sv
// Directed bench: a main-memory model that acknowledges every other cycle,
// a shadow byte model and a log of acknowledged memory words.
module sim_dcache_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_ready;
    logic [15:0] mem_addr;
    logic        mem_wr, mem_strobe;
    logic        mem_ack = 1'b0;
    logic [7:0]  mem_wdata, mem_rdata;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    logic [7:0]  bmem    [4096];
    logic [7:0]  ref_mem [4096];
    logic [15:0] log_addr [512];
    logic        log_wr   [512];
    logic [7:0]  log_data [512];
    int          log_n = 0;

    always #5 clk = ~clk;

    dcache_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .cpu_ready(cpu_ready), .mem_addr(mem_addr), .mem_wr(mem_wr),
        .mem_strobe(mem_strobe), .mem_ack(mem_ack), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] init_val(input int a);
        logic [11:0] x = a[11:0];
        return x[7:0] ^ {x[11:8], x[11:8]} ^ 8'h5A;
    endfunction

    // Memory model: acknowledges every other strobed cycle, logs each word.
    assign mem_rdata = bmem[mem_addr[11:0]];
    always @(posedge clk) begin
        mem_ack <= mem_strobe && !mem_ack;
        if (mem_strobe && mem_ack) begin
            if (mem_wr) bmem[mem_addr[11:0]] <= mem_wdata;
            if (log_n < 512) begin
                log_addr[log_n] <= mem_addr;
                log_wr[log_n]   <= mem_wr;
                log_data[log_n] <= mem_wdata;
            end
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_req(input logic wr, input logic [15:0] a, input logic [7:0] d,
                          output int lowcyc);
        @(negedge clk);
        cpu_sel = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cpu_sel = 1'b0;
        lowcyc = 0;
        while (!cpu_ready) begin
            lowcyc++;
            @(negedge clk);
        end
        if (wr) ref_mem[a[11:0]] = d;
    endtask

    // Checks one 32-word burst in the log; returns the number of bad words.
    task automatic burst_bad(input int start, input logic wr, input logic [15:0] base,
                             output int bad);
        bad = 0;
        for (int i = 0; i < 32; i++) begin
            if (log_wr[start+i] !== wr || log_addr[start+i] !== base + 16'(i)) bad++;
            else if (wr && log_data[start+i] !== ref_mem[base[11:0] + 12'(i)]) bad++;
        end
    endtask

    task automatic t_reset();
        chk(cpu_ready === 1'b1, "R1 ready", int'(cpu_ready), 1);
        chk(mem_strobe === 1'b0, "R1 strobe", int'(mem_strobe), 0);
    endtask

    task automatic t_no_select();
        int s = log_n;
        @(negedge clk);
        cpu_addr = 16'h0123; cpu_wr = 1'b1;
        repeat (5) @(negedge clk);
        chk(cpu_ready === 1'b1, "R2 idle ready", int'(cpu_ready), 1);
        chk(log_n == s && mem_strobe === 1'b0, "R2 no traffic", log_n - s, 0);
    endtask

    task automatic t_first_read();
        int s = log_n, lc, bad;
        do_req(1'b0, 16'h0005, 8'h00, lc);
        chk(log_n - s == 32, "R9 leftover tag misses", log_n - s, 32);
        burst_bad(s, 1'b0, 16'h0000, bad);
        chk(bad == 0, "R5 fill order", bad, 0);
        chk(cpu_rdata === ref_mem[12'h005], "R7 read after fill", cpu_rdata, ref_mem[12'h005]);
        chk(lc > 64, "R2 busy during fill", lc, 65);
    endtask

    task automatic t_read_hit();
        int s = log_n, lc;
        do_req(1'b0, 16'h0009, 8'h00, lc);
        chk(lc == 1 && log_n == s, "R3 hit timing", lc, 1);
        chk(cpu_rdata === ref_mem[12'h009], "R3 hit data", cpu_rdata, ref_mem[12'h009]);
    endtask

    task automatic t_write_hit();
        int s = log_n, lc;
        do_req(1'b1, 16'h0007, 8'hA5, lc);
        chk(lc == 1 && log_n == s, "R4 write hit quiet", lc, 1);
        do_req(1'b0, 16'h0007, 8'h00, lc);
        chk(cpu_rdata === 8'hA5, "R4 readback", cpu_rdata, 8'hA5);
    endtask

    task automatic t_write_miss();
        int s = log_n, lc, bad;
        do_req(1'b1, 16'h0344, 8'h3C, lc);
        chk(log_n - s == 32, "R10 clean miss count", log_n - s, 32);
        burst_bad(s, 1'b0, 16'h0340, bad);
        chk(bad == 0, "R5 write-miss fill", bad, 0);
        do_req(1'b0, 16'h0344, 8'h00, lc);
        chk(cpu_rdata === 8'h3C, "R7 merged write", cpu_rdata, 8'h3C);
        do_req(1'b0, 16'h0345, 8'h00, lc);
        chk(cpu_rdata === ref_mem[12'h345], "R7 neighbour word", cpu_rdata, ref_mem[12'h345]);
    endtask

    task automatic t_dirty_evict(input logic [15:0] old_base, input logic [15:0] a);
        int s = log_n, lc, bad;
        logic [15:0] nb = {a[15:5], 5'd0};
        do_req(1'b0, a, 8'h00, lc);
        chk(log_n - s == 64, "R6 burst count", log_n - s, 64);
        burst_bad(s, 1'b1, old_base, bad);
        chk(bad == 0, "R6 write-back words", bad, 0);
        burst_bad(s + 32, 1'b0, nb, bad);
        chk(bad == 0, "R8 fill after write-back", bad, 0);
        chk(cpu_rdata === ref_mem[a[11:0]], "R7 read after eviction", cpu_rdata, ref_mem[a[11:0]]);
    endtask

    task automatic t_clean_evict();
        int s = log_n, lc, bad;
        do_req(1'b0, 16'h0200, 8'h00, lc);
        chk(log_n - s == 32, "R10 no write-back", log_n - s, 32);
        burst_bad(s, 1'b0, 16'h0200, bad);
        chk(bad == 0, "R10 fill only", bad, 0);
        chk(cpu_rdata === ref_mem[12'h200], "R7 clean evict data", cpu_rdata, ref_mem[12'h200]);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin
            bmem[i] = init_val(i);
            ref_mem[i] = init_val(i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_select();
        t_first_read();
        t_read_hit();
        t_write_hit();
        t_write_miss();
        t_dirty_evict(16'h0000, 16'h0102);
        chk(bmem[12'h007] === 8'hA5, "R6 memory updated", bmem[12'h007], 8'hA5);
        t_clean_evict();
        t_dirty_evict(16'h0340, 16'h0541);
        chk(bmem[12'h344] === 8'h3C, "R6 second line updated", bmem[12'h344], 8'h3C);
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        summary();
    end
endmodule